// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address for one translation request at a time. A request carries the address, an access kind (read, write or execute) and a flag that marks a user-mode access. When translation is on, the walker reads descriptors from an in-memory two-level table through a single-word read port. It returns either a 4 MB superpage found at the first level or a 4 KB page found at the second level. The result carries the physical address, the page size and the read/write/execute grants from the descriptor.

When translation is off, or when a kernel access falls in the lower half of the address space, no table read takes place. Any missing table, missing page, unsupported descriptor type or user permission violation ends the walk with a fault. A fault places a numeric code in a fault status register and the virtual address in a fault address register, and it pulses an instruction-trap or data-trap line together with the completion pulse. Caching of results belongs to the surrounding logic.

The control is one state machine with these states: IDLE (waits for a request), L1_REQ (offers the first-level read), L1_WAIT (waits for the first-level word), L2_REQ (offers the second-level read), L2_WAIT (waits for the second-level word) and FINISH (one-cycle completion). Its transitions are:
- IDLE→FINISH on a bypassed request.
- IDLE→L1_REQ on a request that needs a walk.
- L1_REQ→L1_WAIT and L2_REQ→L2_WAIT when the memory accepts the read.
- L1_WAIT→L2_REQ on a present table pointer.
- L1_WAIT→FINISH on a superpage or a fault.
- L2_WAIT→FINISH on any second-level word.
- FINISH→IDLE always.

Top module: `pgwalk_unit`

## Requirements
- R1: With `xlate_on` low, a request completes without any memory read, with `rsp_paddr` equal to the virtual address, `rsp_perm` = 3'b111 (bit 2 read, bit 1 write, bit 0 execute), `rsp_super` = 0 and no fault.
- R2: With `xlate_on` high, a kernel request (`req_user` = 0) whose address bit 31 is 0 completes without a memory read, with `rsp_paddr` equal to the address with bit 31 set, `rsp_perm` = 3'b111 and `rsp_super` = 0.
- R3: Every other request first reads the word at {`tbl_base`[31:12], vaddr[31:22], 2'b00}.
- R4: A first-level descriptor with type bits [1:0] = 3 and present bit 2 set gives a 4 MB superpage: `rsp_super` = 1, `rsp_paddr` = {desc[31:22], vaddr[21:0]}, and `rsp_perm` = {desc[8], desc[7], desc[6]}.
- R5: A present first-level descriptor of type 0 leads to a second read at {desc[31:12], vaddr[21:12], 2'b00}. A present type-0 second-level word then gives a 4 KB page: `rsp_super` = 0, `rsp_paddr` = {word[31:12], vaddr[11:0]}, and `rsp_perm` from word bits 8, 7, 6.
- R6: Absence faults use these codes: 0x0B for a superpage whose present bit is clear, 0x05 for a type-0 first-level word whose present bit is clear, and 0x08 for a second-level word whose present bit is clear. The present check at the second level comes before the type check.
- R7: An unsupported type (1 or 2 at the first level, or nonzero in a present second-level word) faults with code 0x0E.
- R8: The access kind encoding is 0 read, 1 write, 2 execute and 3 read. A user access to a page that lacks the grant for its kind faults with 0x11 (read), 0x12 (write) or 0x13 (execute). Kernel accesses are never denied, and they still report the descriptor's grants.
- R9: On a fault `rsp_fault` = 1 and `rsp_paddr`, `rsp_perm` and `rsp_super` are 0. `fault_status` takes the code and `fault_addr` takes the virtual address. Both hold their values through later successful requests, and both are 0 after reset.
- R10: A fault on an execute access pulses `itrap`, and a fault on any other access pulses `dtrap`. The pulse lasts exactly the completion cycle. No trap line rises without a fault.
- R11: `req_valid` is taken only while `busy` is low. `busy` stays high from the cycle after acceptance through the single-cycle `done` pulse. Requests offered while busy are ignored.
- R12: `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready`. The response may arrive any number of cycles later on `mem_rsp_valid`, and results do not depend on that latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xlate_on | input | 1 | Translation enable, sampled at acceptance |
| tbl_base | input | 32 | First-level table base; bits [31:12] used |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 read |
| req_user | input | 1 | 1 for a user-mode access |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_fault | output | 1 | Result is a fault |
| rsp_paddr | output | 32 | Physical address |
| rsp_super | output | 1 | 1 for a 4 MB page, 0 for 4 KB |
| rsp_perm | output | 3 | Grants {read, write, execute} |
| fault_status | output | 8 | Code of the last fault |
| fault_addr | output | 32 | Virtual address of the last fault |
| itrap | output | 1 | Instruction-trap pulse |
| dtrap | output | 1 | Data-trap pulse |
| mem_req_valid | output | 1 | Word read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Word read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |

## Verification
Directed requests cover every walk outcome in turn:
- translation off and kernel-low bypass, which separate "no read" from "one read";
- present and absent superpages, and unsupported first-level types;
- absent second-level tables and pages, and bad second-level types;
- pages that grant only one right, accessed by user and by kernel with each access kind, which separate the three permission codes from the kernel's never-deny rule.

Random requests then draw from a mixed table of these descriptors, with random access kinds, privilege, enable and memory latency. This shows that results, read addresses and trap choice do not depend on response timing. A request held on the input while the walker is busy shows that only the first request is served, and successful requests after faults show that the fault registers are retained.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    localparam int PGW_AW      = 32;
    localparam int PGW_CODE_W  = 8;
    localparam int PGW_SUPER_B = 22;   // superpage offset width
    localparam int PGW_PAGE_B  = 12;   // 4 KB offset width
    localparam int PGW_BIT_RD  = 8;
    localparam int PGW_BIT_WR  = 7;
    localparam int PGW_BIT_EX  = 6;
    localparam int PGW_BIT_PR  = 2;

    localparam logic [PGW_CODE_W-1:0] FC_SUPER_ABSENT = 8'h0B;
    localparam logic [PGW_CODE_W-1:0] FC_L2_ABSENT    = 8'h05;
    localparam logic [PGW_CODE_W-1:0] FC_PAGE_ABSENT  = 8'h08;
    localparam logic [PGW_CODE_W-1:0] FC_BAD_TYPE     = 8'h0E;
    localparam logic [PGW_CODE_W-1:0] FC_NO_READ      = 8'h11;
    localparam logic [PGW_CODE_W-1:0] FC_NO_WRITE     = 8'h12;
    localparam logic [PGW_CODE_W-1:0] FC_NO_EXEC      = 8'h13;

    localparam logic [1:0] ACC_WRITE = 2'd1;
    localparam logic [1:0] ACC_EXEC  = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_FINISH
    } pgw_state_e;

    typedef enum logic [1:0] {
        STEP_LEAF,
        STEP_NEXT,
        STEP_FAULT
    } pgw_step_e;
endpackage

// File: rtl/pgw_desc_dec.sv
// Decodes one descriptor word at either table level.
module pgw_desc_dec
    import pgw_pkg::*;
#(
    parameter int AW = PGW_AW,
    parameter int CW = PGW_CODE_W
) (
    input  logic [AW-1:0] desc,
    input  logic          is_l2,
    input  logic [AW-1:0] vaddr,
    output pgw_step_e     step,
    output logic [CW-1:0] code,
    output logic [AW-1:0] paddr,
    output logic          super_pg,
    output logic [2:0]    perm,
    output logic [AW-1:0] next_addr
);
    localparam int IDX_LSB = 2;

    logic       present;
    logic [1:0] kind;
    logic       unused_bits;

    assign present     = desc[PGW_BIT_PR];
    assign kind        = desc[1:0];
    assign unused_bits = ^{desc[PGW_PAGE_B-1:PGW_BIT_RD+1], desc[PGW_BIT_EX-1:PGW_BIT_PR+1]};

    // Second-level word address: pointer frame plus middle index.
    assign next_addr = {desc[AW-1:PGW_PAGE_B], vaddr[PGW_SUPER_B-1:PGW_PAGE_B], {IDX_LSB{1'b0}}};

    always_comb begin
        step     = STEP_FAULT;
        code     = FC_BAD_TYPE;
        paddr    = '0;
        super_pg = 1'b0;
        perm     = {desc[PGW_BIT_RD], desc[PGW_BIT_WR], desc[PGW_BIT_EX]};
        if (is_l2) begin
            if (!present) begin
                code = FC_PAGE_ABSENT;
            end else if (kind == 2'd0) begin
                step  = STEP_LEAF;
                code  = '0;
                paddr = {desc[AW-1:PGW_PAGE_B], vaddr[PGW_PAGE_B-1:0]};
            end
        end else begin
            unique case (kind)
                2'd3: begin
                    if (!present) begin
                        code = FC_SUPER_ABSENT;
                    end else begin
                        step     = STEP_LEAF;
                        code     = '0;
                        super_pg = 1'b1;
                        paddr    = {desc[AW-1:PGW_SUPER_B], vaddr[PGW_SUPER_B-1:0]};
                    end
                end
                2'd0: begin
                    if (!present) begin
                        code = FC_L2_ABSENT;
                    end else begin
                        step = STEP_NEXT;
                        code = '0;
                    end
                end
                default: code = FC_BAD_TYPE;
            endcase
        end
    end
endmodule

// File: rtl/pgw_perm_chk.sv
// User-mode permission check against the leaf grants.
module pgw_perm_chk
    import pgw_pkg::*;
#(
    parameter int CW = PGW_CODE_W
) (
    input  logic [2:0]    perm,
    input  logic [1:0]    acc,
    input  logic          user,
    output logic          deny,
    output logic [CW-1:0] code
);
    logic granted;

    always_comb begin
        if (acc == ACC_EXEC) begin
            granted = perm[0];
            code    = FC_NO_EXEC;
        end else if (acc == ACC_WRITE) begin
            granted = perm[1];
            code    = FC_NO_WRITE;
        end else begin
            granted = perm[2];
            code    = FC_NO_READ;
        end
        deny = user && !granted;
    end
endmodule

// File: rtl/pgwalk_unit.sv
module pgwalk_unit
    import pgw_pkg::*;
#(
    parameter int AW = PGW_AW,
    parameter int CW = PGW_CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xlate_on,
    input  logic [AW-1:0] tbl_base,
    input  logic          req_valid,
    input  logic [AW-1:0] req_vaddr,
    input  logic [1:0]    req_acc,
    input  logic          req_user,
    output logic          busy,
    output logic          done,
    output logic          rsp_fault,
    output logic [AW-1:0] rsp_paddr,
    output logic          rsp_super,
    output logic [2:0]    rsp_perm,
    output logic [CW-1:0] fault_status,
    output logic [AW-1:0] fault_addr,
    output logic          itrap,
    output logic          dtrap,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [AW-1:0] mem_rsp_data
);
    localparam int          L1_IDX_W = AW - PGW_SUPER_B;
    localparam logic [AW-1:0] IO_BIT = {1'b1, {(AW-1){1'b0}}};

    pgw_state_e st_q, st_d;

    logic [AW-1:0] va_q;
    logic [1:0]    acc_q;
    logic          user_q;
    logic [AW-1:0] walk_addr_q;
    logic          res_fault_q;
    logic [AW-1:0] res_paddr_q;
    logic          res_super_q;
    logic [2:0]    res_perm_q;
    logic [CW-1:0] fstat_q;
    logic [AW-1:0] faddr_q;

    logic          accept, bypass_in, rsp_in;
    pgw_step_e     dec_step;
    logic [CW-1:0] dec_code, perm_code, walk_code;
    logic [AW-1:0] dec_paddr, dec_next;
    logic          dec_super, perm_deny, walk_fault;
    logic [2:0]    dec_perm;
    logic          unused_base;

    assign unused_base = ^tbl_base[PGW_PAGE_B-1:0];
    assign accept      = (st_q == ST_IDLE) && req_valid;
    assign bypass_in   = !xlate_on || (!req_user && !req_vaddr[AW-1]);
    assign rsp_in      = mem_rsp_valid && ((st_q == ST_L1_WAIT) || (st_q == ST_L2_WAIT));

    pgw_desc_dec #(.AW(AW), .CW(CW)) u_dec (
        .desc      (mem_rsp_data),
        .is_l2     (st_q == ST_L2_WAIT),
        .vaddr     (va_q),
        .step      (dec_step),
        .code      (dec_code),
        .paddr     (dec_paddr),
        .super_pg  (dec_super),
        .perm      (dec_perm),
        .next_addr (dec_next)
    );

    pgw_perm_chk #(.CW(CW)) u_perm (
        .perm (dec_perm),
        .acc  (acc_q),
        .user (user_q),
        .deny (perm_deny),
        .code (perm_code)
    );

    assign walk_fault = (dec_step == STEP_FAULT) || ((dec_step == STEP_LEAF) && perm_deny);
    assign walk_code  = (dec_step == STEP_FAULT) ? dec_code : perm_code;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (req_valid)     st_d = bypass_in ? ST_FINISH : ST_L1_REQ;
            ST_L1_REQ:  if (mem_req_ready) st_d = ST_L1_WAIT;
            ST_L1_WAIT: if (mem_rsp_valid) st_d = (dec_step == STEP_NEXT) ? ST_L2_REQ : ST_FINISH;
            ST_L2_REQ:  if (mem_req_ready) st_d = ST_L2_WAIT;
            ST_L2_WAIT: if (mem_rsp_valid) st_d = ST_FINISH;
            ST_FINISH:                     st_d = ST_IDLE;
            default:                       st_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        busy          = (st_q != ST_IDLE);
        done          = (st_q == ST_FINISH);
        mem_req_valid = (st_q == ST_L1_REQ) || (st_q == ST_L2_REQ);
        mem_req_addr  = walk_addr_q;
        rsp_fault     = res_fault_q;
        rsp_paddr     = res_paddr_q;
        rsp_super     = res_super_q;
        rsp_perm      = res_perm_q;
        fault_status  = fstat_q;
        fault_addr    = faddr_q;
        itrap         = done && res_fault_q && (acc_q == ACC_EXEC);
        dtrap         = done && res_fault_q && (acc_q != ACC_EXEC);
    end

    // Request capture, walk results and fault registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q        <= '0;
            acc_q       <= '0;
            user_q      <= 1'b0;
            walk_addr_q <= '0;
            res_fault_q <= 1'b0;
            res_paddr_q <= '0;
            res_super_q <= 1'b0;
            res_perm_q  <= '0;
            fstat_q     <= '0;
            faddr_q     <= '0;
        end else if (accept) begin
            va_q        <= req_vaddr;
            acc_q       <= req_acc;
            user_q      <= req_user;
            walk_addr_q <= {tbl_base[AW-1:PGW_PAGE_B], req_vaddr[AW-1 -: L1_IDX_W], 2'b00};
            res_fault_q <= 1'b0;
            res_super_q <= 1'b0;
            res_perm_q  <= 3'b111;
            res_paddr_q <= xlate_on ? (req_vaddr | IO_BIT) : req_vaddr;
        end else if (rsp_in) begin
            if (dec_step == STEP_NEXT && st_q == ST_L1_WAIT) begin
                walk_addr_q <= dec_next;
            end else if (walk_fault) begin
                res_fault_q <= 1'b1;
                res_paddr_q <= '0;
                res_super_q <= 1'b0;
                res_perm_q  <= '0;
                fstat_q     <= walk_code;
                faddr_q     <= va_q;
            end else begin
                res_fault_q <= 1'b0;
                res_paddr_q <= dec_paddr;
                res_super_q <= dec_super;
                res_perm_q  <= dec_perm;
            end
        end
    end
endmodule

// File: rtl/pgw_checker.sv
module pgw_checker
    import pgw_pkg::*;
#(
    parameter int AW = PGW_AW,
    parameter int CW = PGW_CODE_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          xlate_on,
    input logic          req_valid,
    input logic [AW-1:0] req_vaddr,
    input logic [1:0]    req_acc,
    input logic          req_user,
    input logic          busy,
    input logic          done,
    input logic          rsp_fault,
    input logic [AW-1:0] rsp_paddr,
    input logic          rsp_super,
    input logic [2:0]    rsp_perm,
    input logic [AW-1:0] fault_addr,
    input logic          itrap,
    input logic          dtrap,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic [AW-1:0] mem_req_addr
);
    logic [AW-1:0] t_va;
    logic [1:0]    t_acc;
    logic          t_user, t_xon;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_va <= '0; t_acc <= '0; t_user <= 1'b0; t_xon <= 1'b0;
        end else if (req_valid && !busy) begin
            t_va <= req_vaddr; t_acc <= req_acc; t_user <= req_user; t_xon <= xlate_on;
        end
    end

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    a_r11_done_busy:  assert property (@(posedge clk) disable iff (!rst_n) done |-> busy);
    a_r12_req_hold:   assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
    a_r12_req_busy:   assert property (@(posedge clk) disable iff (!rst_n) mem_req_valid |-> busy);
    a_r10_trap_excl:  assert property (@(posedge clk) disable iff (!rst_n)
        (itrap || dtrap) |-> (done && rsp_fault && !(itrap && dtrap)));
    a_r10_trap_kind:  assert property (@(posedge clk) disable iff (!rst_n)
        (done && rsp_fault) |-> (itrap == (t_acc == ACC_EXEC)));
    a_r9_fault_addr:  assert property (@(posedge clk) disable iff (!rst_n)
        (done && rsp_fault) |-> (fault_addr == t_va));
    a_r1_off_ident:   assert property (@(posedge clk) disable iff (!rst_n)
        (done && !t_xon) |-> (rsp_paddr == t_va && rsp_perm == 3'b111 && !rsp_fault));
    a_r2_no_walk:     assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (t_xon && (t_user || t_va[AW-1])));
    a_r4_super_off:   assert property (@(posedge clk) disable iff (!rst_n)
        (done && !rsp_fault && rsp_super) |-> (rsp_paddr[PGW_SUPER_B-1:0] == t_va[PGW_SUPER_B-1:0]));
endmodule

bind pgwalk_unit pgw_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .xlate_on      (xlate_on),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .req_acc       (req_acc),
    .req_user      (req_user),
    .busy          (busy),
    .done          (done),
    .rsp_fault     (rsp_fault),
    .rsp_paddr     (rsp_paddr),
    .rsp_super     (rsp_super),
    .rsp_perm      (rsp_perm),
    .fault_addr    (fault_addr),
    .itrap         (itrap),
    .dtrap         (dtrap),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/pgwalk_unit_tb.sv
module pgwalk_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlate_on = 1'b0;
    logic [31:0] tbl_base = 32'h0010_0000;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        req_user = 1'b0;
    logic        busy, done, rsp_fault, rsp_super, itrap, dtrap, mem_req_valid;
    logic [31:0] rsp_paddr, fault_addr, mem_req_addr;
    logic [2:0]  rsp_perm;
    logic [7:0]  fault_status;
    logic        mem_req_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    always #2 clk = ~clk;   // 250 MHz

    pgwalk_unit u_dut (
        .clk(clk), .rst_n(rst_n), .xlate_on(xlate_on), .tbl_base(tbl_base),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_acc(req_acc), .req_user(req_user),
        .busy(busy), .done(done), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .rsp_super(rsp_super), .rsp_perm(rsp_perm), .fault_status(fault_status),
        .fault_addr(fault_addr), .itrap(itrap), .dtrap(dtrap),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    int nchk = 0;
    int nfail = 0;
    logic [31:0] mem [int unsigned];
    logic [31:0] rd_log [4];
    int          rd_n = 0;
    logic [7:0]  exp_fs = '0;
    logic [31:0] exp_fa = '0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference walk computed from the requirements.
    function automatic void model(input logic [31:0] va, input logic [1:0] acc, input logic usr,
                                  input logic xon, input logic [31:0] base,
                                  output logic f, output logic [7:0] c, output logic [31:0] pa,
                                  output logic sp, output logic [2:0] pm, output int nr,
                                  output logic [31:0] a1, output logic [31:0] a2, output string tag);
        logic [31:0] d, d2, leaf;
        logic have_leaf, ok;
        f = 0; c = 0; pa = 0; sp = 0; pm = 0; nr = 0; a1 = 0; a2 = 0; have_leaf = 0; leaf = 0;
        if (!xon) begin pa = va; pm = 3'b111; tag = "R1"; return; end
        if (!usr && !va[31]) begin pa = va | 32'h8000_0000; pm = 3'b111; tag = "R2"; return; end
        a1 = (base & 32'hFFFF_F000) | ((va >> 20) & 32'hFFC);
        d = rd(a1); nr = 1;
        if (d[1:0] == 2'd3) begin
            if (!d[2]) begin f = 1; c = 8'h0B; tag = "R6"; end
            else begin pa = (d & 32'hFFC0_0000) | (va & 32'h003F_FFFF); sp = 1; leaf = d; have_leaf = 1; tag = "R4"; end
        end else if (d[1:0] == 2'd0) begin
            if (!d[2]) begin f = 1; c = 8'h05; tag = "R6"; end
            else begin
                a2 = (d & 32'hFFFF_F000) | ((va >> 10) & 32'hFFC);
                d2 = rd(a2); nr = 2;
                if (!d2[2]) begin f = 1; c = 8'h08; tag = "R6"; end
                else if (d2[1:0] != 2'd0) begin f = 1; c = 8'h0E; tag = "R7"; end
                else begin pa = (d2 & 32'hFFFF_F000) | (va & 32'hFFF); leaf = d2; have_leaf = 1; tag = "R5"; end
            end
        end else begin
            f = 1; c = 8'h0E; tag = "R7";
        end
        if (have_leaf) begin
            pm = {leaf[8], leaf[7], leaf[6]};
            ok = (acc == 2'd2) ? pm[0] : (acc == 2'd1) ? pm[1] : pm[2];
            if (usr && !ok) begin
                f = 1; tag = "R8";
                c = (acc == 2'd2) ? 8'h13 : (acc == 2'd1) ? 8'h12 : 8'h11;
            end
        end
        if (f) begin pa = 0; sp = 0; pm = 0; end
    endfunction

    // Memory responder: random accept delay and random data latency.
    initial begin
        bit pend = 0;
        int lat = 0;
        logic [31:0] pa_q = '0;
        forever begin
            @(negedge clk);
            mem_req_ready = 1'b0;
            mem_rsp_valid = 1'b0;
            if (pend) begin
                if (lat == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rd(pa_q);
                    pend = 0;
                end else lat--;
            end else if (mem_req_valid && ($urandom % 3 == 0)) begin
                mem_req_ready = 1'b1;
                pa_q = mem_req_addr;
                if (rd_n < 4) rd_log[rd_n] = mem_req_addr;
                rd_n++;
                pend = 1;
                lat = $urandom % 4;
            end
        end
    end

    task automatic xact(input logic [31:0] va, input logic [1:0] acc, input logic usr,
                        input logic xon, input bit spam);
        logic f, sp; logic [7:0] c; logic [31:0] pa, a1, a2; logic [2:0] pm; int nr; string tag;
        int cyc;
        model(va, acc, usr, xon, tbl_base, f, c, pa, sp, pm, nr, a1, a2, tag);
        if (f) begin exp_fs = c; exp_fa = va; end
        rd_n = 0;
        @(negedge clk);
        xlate_on = xon; req_vaddr = va; req_acc = acc; req_user = usr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!done && cyc < 500) begin
            if (spam) begin
                req_valid = 1'b1; req_vaddr = ~va; req_user = ~usr; req_acc = acc ^ 2'd1;
            end
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        chk(done, "R11 done", {31'b0, done}, 32'd1);
        chk(busy, "R11 busy", {31'b0, busy}, 32'd1);
        chk(rsp_fault == f, tag, {31'b0, rsp_fault}, {31'b0, f});
        chk(rsp_paddr == pa, tag, rsp_paddr, pa);
        chk(rsp_super == sp, tag, {31'b0, rsp_super}, {31'b0, sp});
        chk(rsp_perm == pm, tag, {29'b0, rsp_perm}, {29'b0, pm});
        chk(fault_status == exp_fs, "R9 status", {24'b0, fault_status}, {24'b0, exp_fs});
        chk(fault_addr == exp_fa, "R9 addr", fault_addr, exp_fa);
        chk(itrap == (f && acc == 2'd2), "R10 itrap", {31'b0, itrap}, {31'b0, f && acc == 2'd2});
        chk(dtrap == (f && acc != 2'd2), "R10 dtrap", {31'b0, dtrap}, {31'b0, f && acc != 2'd2});
        chk(rd_n == nr, "R12 reads", rd_n, nr);
        if (nr >= 1 && rd_n >= 1) chk(rd_log[0] == a1, "R3", rd_log[0], a1);
        if (nr >= 2 && rd_n >= 2) chk(rd_log[1] == a2, "R5 l2addr", rd_log[1], a2);
        @(negedge clk);
        chk(!done && !busy && !itrap && !dtrap, "R11 pulse", {29'b0, done, busy, itrap | dtrap}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] tops [7];
        void'($urandom(32'd20240611));
        // first-level entries (base 0x0010_0000)
        mem[32'h0010_0000 + 32'h200*4] = 32'h4040_01C7;  // superpage rwx
        mem[32'h0010_0000 + 32'h201*4] = 32'h4080_0003;  // superpage absent
        mem[32'h0010_0000 + 32'h202*4] = 32'h0000_0005;  // type 1
        mem[32'h0010_0000 + 32'h203*4] = 32'h0030_0000;  // table absent
        mem[32'h0010_0000 + 32'h204*4] = 32'h0030_0004;  // table at 0x0030_0000
        mem[32'h0010_0000 + 32'h205*4] = 32'h0C00_0007;  // superpage, no grants
        mem[32'h0010_0000 + 32'h010*4] = 32'h0050_0004;  // table at 0x0050_0000 (user low)
        mem[32'h0030_0004] = 32'h1234_51C4;  // rwx page
        mem[32'h0030_0008] = 32'h1234_6000;  // absent page
        mem[32'h0030_000C] = 32'h1234_7006;  // bad type
        mem[32'h0030_0010] = 32'h1234_8104;  // read only
        mem[32'h0030_0014] = 32'h1234_9084;  // write only
        mem[32'h0030_0018] = 32'h1234_A044;  // exec only
        mem[32'h0050_0004] = 32'h0ABC_D1C4;
        mem[32'h0050_0008] = 32'h0ABC_E0C4;

        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_req_valid, "R11 reset", {29'b0, busy, done, mem_req_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fault_status == 8'h00 && fault_addr == 32'h0, "R9 reset", {24'b0, fault_status}, 32'd0);
        chk(!itrap && !dtrap, "R10 reset", {30'b0, itrap, dtrap}, 32'd0);

        xact(32'h8012_3456, 2'd0, 1'b1, 1'b0, 0);  // R1 off
        xact(32'h1234_5678, 2'd1, 1'b0, 1'b1, 0);  // R2 kernel low
        xact(32'h8012_3456, 2'd2, 1'b0, 1'b1, 0);  // R4 kernel super
        xact(32'h803F_FFFC, 2'd1, 1'b1, 1'b1, 0);  // R4 user super
        xact(32'h8050_0000, 2'd0, 1'b1, 1'b1, 0);  // R6 0x0B
        xact(32'h8080_0010, 2'd2, 1'b1, 1'b1, 0);  // R7 L1 type
        xact(32'h80C0_0000, 2'd0, 1'b0, 1'b1, 0);  // R6 0x05
        xact(32'h8100_1ABC, 2'd2, 1'b1, 1'b1, 0);  // R5 page ok
        xact(32'h8100_2000, 2'd1, 1'b1, 1'b1, 0);  // R6 0x08
        xact(32'h8100_3000, 2'd0, 1'b1, 1'b1, 0);  // R7 L2 type
        xact(32'h8100_4010, 2'd1, 1'b1, 1'b1, 0);  // R8 0x12
        xact(32'h8100_4020, 2'd0, 1'b1, 1'b1, 0);  // R8 read ok; R9 retains
        xact(32'h8100_4030, 2'd2, 1'b1, 1'b1, 0);  // R8 0x13 itrap
        xact(32'h8100_5040, 2'd3, 1'b1, 1'b1, 0);  // R8 0x11 (code 3 reads)
        xact(32'h8100_5040, 2'd0, 1'b0, 1'b1, 0);  // R8 kernel not denied
        xact(32'h8140_0000, 2'd1, 1'b0, 1'b1, 0);  // R8 kernel on no-grant super
        xact(32'h8100_6FFF, 2'd2, 1'b1, 1'b1, 1);  // R11 requests while busy
        xact(32'h8012_0000, 2'd0, 1'b1, 1'b0, 1);  // R11 bypass with spam

        tops = '{32'h200, 32'h201, 32'h202, 32'h203, 32'h204, 32'h205, 32'h010};
        for (int i = 0; i < 400; i++) begin
            logic [31:0] va;
            va = {tops[$urandom % 7][9:0], 10'($urandom % 7), 12'($urandom)};
            if ($urandom % 8 == 0) va = $urandom;
            xact(va, 2'($urandom), 1'($urandom), ($urandom % 10) != 0, 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule